// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block walks a stepper motor through its four coil phases. It holds one of four phase states, and each state drives a fixed two-hot pattern on a four-bit coil output. An internal prescaler divides the system clock down to a single-cycle step strobe, and the state moves by exactly one position on each strobe. With the nominal divide ratio and a 50 MHz clock, that is one step per second.

A direction input chooses which way the machine goes around the ring of states, and so which way the shaft turns. The direction is sampled only on the strobe cycle. A synchronous reset returns the machine to its home phase and restarts the prescaler, so the first step after reset comes a full period later. The divide ratio is a parameter, which lets a testbench use a short period.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to the home phase, `coil` = 4'b0101, and the prescaler count is cleared. This holds even when reset arrives in the middle of a step period.
- R2: The four phases drive these `coil` values (bit 3 on the left): home 4'b0101, phase one 4'b0110, phase two 4'b1010, phase three 4'b1001. `coil` depends only on the current phase.
- R3: When `dir_fwd` = 1 on a step, the phase advances home → one → two → three → home. For example, phase one steps to phase two (4'b0110 → 4'b1010).
- R4: When `dir_fwd` = 0 on a step, the phase moves the other way: home → three → two → one → home.
- R5: After reset, the first step happens at the DIV-th rising edge, counting from the first edge at which `rst` is low. Each later step comes exactly DIV edges after the one before.
- R6: `coil` holds its value on every edge that is not a step edge.
- R7: `dir_fwd` is sampled only at the step edge. A change made between steps has no effect if it is undone before the step. A change that is present at the step edge takes effect at that step.
- R8: Out of reset, `coil` always has exactly two bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dir_fwd | input | 1 | Step direction: 1 forward, 0 reverse |
| coil | output | 4 | Coil phase pattern |

## Verification
The bench counts edges from the release of reset, so that a prescaler that is off by one fires its step one edge early or one edge late, and the bench sees the wrong cycle. It toggles direction between steps and restores it before the step edge; a design that latches direction early would then step the wrong way. It also flips direction on the cycle just before the step, which catches a design that reads a stale copy of the input. Finally, it resets the machine in the middle of a period. A design that does not clear the counter would step too soon after the reset.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    typedef enum logic [1:0] {
        PH_HOME  = 2'd0,
        PH_ONE   = 2'd1,
        PH_TWO   = 2'd2,
        PH_THREE = 2'd3
    } phase_e;

    // Coil pattern driven in each phase; bit 3 first.
    function automatic logic [3:0] coil_of(phase_e ph);
        logic [3:0] pat;
        case (ph)
            PH_HOME:  pat = 4'b0101;
            PH_ONE:   pat = 4'b0110;
            PH_TWO:   pat = 4'b1010;
            default:  pat = 4'b1001;
        endcase
        return pat;
    endfunction

    // Neighbour on the ring of phases in the chosen direction.
    function automatic phase_e next_phase(phase_e ph, logic fwd);
        logic [1:0] raw;
        raw = fwd ? (2'(ph) + 2'd1) : (2'(ph) - 2'd1);
        return phase_e'(raw);
    endfunction

endpackage

// File: rtl/step_prescaler.sv
module step_prescaler #(
    parameter int unsigned DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_s;

    pre_s pre_d, pre_q;
    logic tick;

    always_comb begin
        pre_d = pre_q;
        tick  = (pre_q.cnt == LAST);
        if (rst) begin
            pre_d.cnt = '0;
        end else if (tick) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        pre_q <= pre_d;
    end

    assign tick_o = tick;

    // R5: after a strobe the count starts over from zero
    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pre_q.cnt == '0));

    // R1: reset clears the count
    a_r1_count_cleared: assert property (@(posedge clk)
        rst |=> (pre_q.cnt == '0));

    generate
        if (DIV > 1) begin : g_gap
            // R5: strobes are never back to back when the period exceeds one
            a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import stepseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       step_i,
    input  logic       fwd_i,
    output logic [3:0] coil_o
);
    typedef struct packed {
        phase_e phase;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (rst) begin
            fsm_d.phase = PH_HOME;
        end else if (step_i) begin
            fsm_d.phase = next_phase(fsm_q.phase, fwd_i);
        end
    end

    always_ff @(posedge clk) begin
        fsm_q <= fsm_d;
    end

    assign coil_o = coil_of(fsm_q.phase);

    // R1: reset forces the home phase
    a_r1_home: assert property (@(posedge clk)
        rst |=> (fsm_q.phase == PH_HOME));

    // R6: no strobe, no movement
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> $stable(coil_o));

    // R3: forward strobe advances by one
    a_r3_forward: assert property (@(posedge clk) disable iff (rst)
        (step_i && fwd_i) |=> (2'(fsm_q.phase) == 2'(2'($past(fsm_q.phase)) + 2'd1)));

    // R4: reverse strobe retreats by one
    a_r4_reverse: assert property (@(posedge clk) disable iff (rst)
        (step_i && !fwd_i) |=> (2'(fsm_q.phase) == 2'(2'($past(fsm_q.phase)) - 2'd1)));

    // R8: exactly two coils energised
    a_r8_two_hot: assert property (@(posedge clk) disable iff (rst)
        $countones(coil_o) == 2);

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
    parameter int unsigned DIV = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_fwd,
    output logic [3:0] coil
);
    logic step;

    step_prescaler #(.DIV(DIV)) prescale_i (
        .clk    (clk),
        .rst    (rst),
        .tick_o (step)
    );

    phase_fsm fsm_i (
        .clk    (clk),
        .rst    (rst),
        .step_i (step),
        .fwd_i  (dir_fwd),
        .coil_o (coil)
    );

endmodule

// File: tb/stepper_phase_seq_tb_top.sv
module stepper_phase_seq_tb_top;
    localparam int unsigned DIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir_fwd = 1'b1;
    logic [3:0] coil;

    int total = 0;
    int bad = 0;
    logic [3:0] cur_pat;

    stepper_phase_seq #(.DIV(DIV)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .dir_fwd (dir_fwd),
        .coil    (coil)
    );

    always #4 clk = ~clk;

    // Patterns in forward ring order (R2)
    function automatic logic [3:0] pat_at(int idx);
        case (idx & 3)
            0: return 4'b0101;
            1: return 4'b0110;
            2: return 4'b1010;
            default: return 4'b1001;
        endcase
    endfunction

    int model_idx = 0;

    task automatic chk(input string req, input logic [3:0] exp);
        total++;
        if (coil !== exp) begin
            bad++;
            $display("FAIL %s: coil=%b expected=%b at %0t", req, coil, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_idx = 0;
        cur_pat = pat_at(0);
    endtask

    // One full period: hold until the step edge, then the new pattern.
    task automatic step_check(input string req, input logic fwd);
        dir_fwd = fwd;
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        chk("R6", cur_pat);
        @(posedge clk);
        @(negedge clk);
        model_idx = fwd ? model_idx + 1 : model_idx + 3;
        cur_pat = pat_at(model_idx);
        chk(req, cur_pat);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", 4'b0101);
        total++;
        if ($countones(coil) != 2) begin
            bad++;
            $display("FAIL R8: coil=%b expected two bits set", coil);
        end
    endtask

    task automatic t_forward();
        do_reset();
        for (int i = 0; i < 5; i++) step_check("R3", 1'b1);
    endtask

    task automatic t_reverse();
        do_reset();
        for (int i = 0; i < 5; i++) step_check("R4", 1'b0);
    endtask

    task automatic t_first_step_timing();
        do_reset();
        dir_fwd = 1'b1;
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        chk("R5", 4'b0101);
        @(posedge clk);
        @(negedge clk);
        chk("R5", 4'b0110);
    endtask

    task automatic t_reset_midway();
        do_reset();
        step_check("R3", 1'b1);
        step_check("R3", 1'b1);
        repeat (2) @(posedge clk);
        do_reset();
        chk("R1", 4'b0101);
        step_check("R1", 1'b1);
    endtask

    task automatic t_dir_glitch();
        do_reset();
        dir_fwd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dir_fwd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        dir_fwd = 1'b1;
        repeat (DIV - 3) @(posedge clk);
        @(negedge clk);
        chk("R7", 4'b0101);
        @(posedge clk);
        @(negedge clk);
        chk("R7", 4'b0110);
    endtask

    task automatic t_dir_late();
        do_reset();
        dir_fwd = 1'b1;
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk);
        dir_fwd = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R7", 4'b1001);
        dir_fwd = 1'b1;
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        cur_pat = 4'b0101;
        t_reset_state();
        t_first_step_timing();
        t_forward();
        t_reverse();
        t_reset_midway();
        t_dir_glitch();
        t_dir_late();
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_up();
    end

endmodule